// File: doc/BRIEF.md
# Split-Byte Conversion Result Register

This block holds the 10-bit result of an analog-to-digital conversion and presents it on a byte-wide read bus as two read-only bytes. The low byte sits at address 0x78 and the high byte at 0x79. A configuration input chooses between right alignment, where the value fills the low end of the 16-bit pair, and left alignment, where its eight most significant bits fill the high byte.

A converter delivers each result with a one-cycle completion strobe. Reading the low byte freezes the held value until the high byte is read, so a result that arrives during a two-byte read cannot leave the two bytes from different conversions. A result that arrives while the value is frozen is dropped and raises a sticky flag. Alignment is applied on the read path, so changing it remaps the held value without a new conversion.

Top module: `adc_result_regs`

## Requirements
- R1: After reset both bytes read 0x00 and `result_lost` is 0.
- R2: With `left_align` = 0, address 0x78 returns result bits 7:0, and address 0x79 returns result bits 9:8 in its bits 1:0 with bits 7:2 zero.
- R3: With `left_align` = 1, address 0x79 returns result bits 9:2, and address 0x78 returns result bits 1:0 in its bits 7:6 with bits 5:0 zero.
- R4: While no lock is held, a `conv_done` pulse stores `conv_result`, and the new value is visible on reads from the next cycle on.
- R5: A read of 0x78 sets the lock from the next cycle. A `conv_done` in the same cycle as that read, or while the lock is held, does not change the stored value.
- R6: A read of 0x79 clears the lock from the next cycle. A read of 0x79 with no lock held changes nothing, so the next conversion is stored.
- R7: A conversion dropped under R5 sets `result_lost`, which stays set until reset.
- R8: The alignment is applied when the bytes are read. Toggling `left_align` changes the bytes returned for the same stored value.
- R9: `rd_data` is 0x00 when `rd_en` is low or when `rd_addr` is neither 0x78 nor 0x79. Such cycles do not set the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle strobe marking a finished conversion |
| conv_result | input | 10 | Conversion value, sampled with `conv_done` |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| left_align | input | 1 | 1 selects left alignment, 0 selects right alignment |
| rd_data | output | 8 | Read data, combinational from address and held value |
| result_lost | output | 1 | Sticky flag for a dropped conversion |

## Verification
On every cycle the assertions check the following: the held value stays unchanged while locked, a low-byte read sets the lock and a high-byte read clears it, an unlocked conversion is captured, the lost flag is sticky, and unused addresses return zero. Only the bench scenarios can show the full byte mapping in both alignments, a complete two-byte read that stays coherent while a conversion is dropped in between, remapping on an alignment toggle, and a high-byte read on its own that leaves later captures unaffected.

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h78,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h79
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [9:0]        conv_result,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              left_align,
  output logic [7:0]        rd_data,
  output logic              result_lost
);
  localparam int RES_W = 10;
  localparam int BYTE_W = 8;
  localparam int PAD_W = 2 * BYTE_W - RES_W;

  logic [RES_W-1:0] res_q;
  logic             lock_q;
  logic             lost_q;

  wire lo_rd  = rd_en && (rd_addr == LO_ADDR);
  wire hi_rd  = rd_en && (rd_addr == HI_ADDR);
  wire accept = conv_done && !lock_q && !lo_rd;
  wire drop   = conv_done && !accept;

  wire [2*BYTE_W-1:0] view = left_align ? {res_q, {PAD_W{1'b0}}}
                                        : {{PAD_W{1'b0}}, res_q};

  assign rd_data = lo_rd ? view[BYTE_W-1:0] :
                   hi_rd ? view[2*BYTE_W-1:BYTE_W] : '0;
  assign result_lost = lost_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      lock_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if (accept) res_q <= conv_result;
      if (drop)   lost_q <= 1'b1;
      if (lo_rd)       lock_q <= 1'b1;
      else if (hi_rd)  lock_q <= 1'b0;
    end
  end
endmodule

module adc_result_regs_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h78,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h79
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [9:0]        conv_result,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              result_lost,
  input logic [9:0]        res_q,
  input logic              lock_q
);
  // R5
  held_while_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (res_q == $past(res_q)));
  // R5
  lo_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == LO_ADDR) |=> lock_q);
  // R6
  hi_read_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == HI_ADDR) |=> !lock_q);
  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !lock_q && !(rd_en && rd_addr == LO_ADDR)) |=> (res_q == $past(conv_result)));
  // R7
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_lost |=> result_lost);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || (rd_addr != LO_ADDR && rd_addr != HI_ADDR)) |-> (rd_data == 8'h00));
endmodule

bind adc_result_regs adc_result_regs_chk #(
  .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .result_lost(result_lost),
  .res_q(res_q), .lock_q(lock_q)
);

// File: tb/tb_adc_result_regs.sv
module tb_adc_result_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic       left_align = 1'b0;
  logic [7:0] rd_data;
  logic       result_lost;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_result_regs dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
    .rd_en(rd_en), .rd_addr(rd_addr), .left_align(left_align),
    .rd_data(rd_data), .result_lost(result_lost)
  );

  // {result, align, expected low byte, expected high byte}
  localparam logic [26:0] VEC [12] = '{
    {10'h3FF, 1'b0, 8'hFF, 8'h03}, {10'h3FF, 1'b1, 8'hC0, 8'hFF},
    {10'h155, 1'b0, 8'h55, 8'h01}, {10'h155, 1'b1, 8'h40, 8'h55},
    {10'h2AA, 1'b0, 8'hAA, 8'h02}, {10'h2AA, 1'b1, 8'h80, 8'hAA},
    {10'h001, 1'b0, 8'h01, 8'h00}, {10'h001, 1'b1, 8'h40, 8'h00},
    {10'h200, 1'b0, 8'h00, 8'h02}, {10'h200, 1'b1, 8'h00, 8'h80},
    {10'h0C3, 1'b0, 8'hC3, 8'h00}, {10'h0C3, 1'b1, 8'hC0, 8'h30}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [9:0] v);
    @(negedge clk);
    conv_done = 1'b1; conv_result = v;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 lost", {7'd0, result_lost}, 8'h00);
    rd(8'h78, d); check("R1 low", d, 8'h00);
    rd(8'h79, d); check("R1 high", d, 8'h00);

    // R2 R3 R4 vector walk
    for (int i = 0; i < 12; i++) begin
      left_align = VEC[i][16];
      convert(VEC[i][26:17]);
      rd(8'h78, d); check(VEC[i][16] ? "R3 low" : "R2 low", d, VEC[i][15:8]);
      rd(8'h79, d); check(VEC[i][16] ? "R3 high" : "R2 high", d, VEC[i][7:0]);
    end

    // R5 R7 lock holds across a dropped conversion
    left_align = 1'b0;
    convert(10'h1A5);
    rd(8'h78, d); check("R5 low", d, 8'hA5);
    convert(10'h35A);
    check("R7 lost set", {7'd0, result_lost}, 8'h01);
    rd(8'h79, d); check("R5 high coherent", d, 8'h01);
    // R6 released: next conversion stored
    convert(10'h35A);
    rd(8'h78, d); check("R6 capture after release", d, 8'h5A);
    rd(8'h79, d); check("R6 high", d, 8'h03);

    // R5 conversion in the same cycle as the low read is dropped
    convert(10'h011);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h78; conv_done = 1'b1; conv_result = 10'h2EE;
    #1 check("R5 same-cycle low", rd_data, 8'h11);
    @(negedge clk);
    rd_en = 1'b0; conv_done = 1'b0;
    rd(8'h79, d); check("R5 same-cycle high", d, 8'h00);

    // R8 alignment toggle on held value 0x011
    left_align = 1'b1;
    rd(8'h79, d); check("R8 left high", d, 8'h04);
    rd(8'h78, d); check("R8 left low", d, 8'h40);
    left_align = 1'b0;
    rd(8'h78, d); check("R8 right low", d, 8'h11);
    rd(8'h79, d); check("R8 right high", d, 8'h00);

    // R6 high read alone with no lock leaves capture enabled
    left_align = 1'b1;
    convert(10'h3C0);
    rd(8'h79, d); check("R6 high only", d, 8'hF0);
    convert(10'h0FC);
    rd(8'h79, d); check("R6 high only next", d, 8'h3F);

    // R9 idle and other addresses read zero and do not lock
    left_align = 1'b0;
    @(negedge clk); rd_addr = 8'h78; #1 check("R9 rd_en low", rd_data, 8'h00);
    rd(8'h7A, d); check("R9 other addr", d, 8'h00);
    rd(8'h77, d); check("R9 other addr2", d, 8'h00);
    convert(10'h123);
    rd(8'h78, d); check("R9 no lock low", d, 8'h23);
    rd(8'h79, d); check("R9 no lock high", d, 8'h01);

    // R7 flag still set
    check("R7 sticky", {7'd0, result_lost}, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule